// File: doc/BRIEF.md
# Video Stream Resolution Detector

The detector sits beside a parallel video stream and measures its active geometry. Each clock carries one sample with three flags: an active-video flag, an end-of-line flag on the last sample of every line, and a field-identity flag. A line that holds at least one active sample is an active line. A line with none is a blank line. The block counts active samples per line and active lines per field. It decides whether line length is steady and whether the stream is interlaced, and it publishes the results as read-only words on a small 32-bit register bus.

The first blank line seen while the external lock input is high synchronises the detector. A field opens at the first active line after synchronisation and closes at the next blank line; that closing is the field end. A frame boundary is the first active sample of a field whose field flag is 0. The sample stream is copied to the output, gated by a go bit. A change to the go bit takes effect only at a frame boundary, so output always begins on a whole frame.

Top module: `vid_res_detect`

## Requirements
- R1: The status word (bus address 0) has lock at bit 11, resolution valid at bit 10, stable at bit 8, interlaced at bit 7 and producing at bit 0. Every other bit reads 0. After reset every field is 0, and the lock bit always follows the lock input.
- R2: Bus word addresses are: 1 sample count, 2 field-0 line count, 3 field-1 line count, 4 control (go in bit 0, write-only, reads 0). Any other address reads 0, and the upper 16 bits of the count words read 0.
- R3: At each field end the sample count takes the number of active samples in the last active line of that field.
- R4: At each field end the number of active lines in the field is written to the field-0 count if the field flag was 0 and to the field-1 count if it was 1. The other count keeps its value. Lines seen before synchronisation never update any count.
- R5: After each active line, stable reads 1 exactly when at least two of the last three active line lengths are equal. With fewer than three lines since lock, it reads 0.
- R6: Resolution valid is set at a field end while stable is 1. It clears as soon as an active line leaves stable at 0, and it is never 1 while stable is 0.
- R7: At each field end after the first one since lock, interlaced is set if this field's flag differs from the previous field's flag and cleared if it is the same.
- R8: Writing 1 to go starts output at the next frame boundary, and writing 0 stops it at the next frame boundary. Output valid is high only for active samples while producing, and output data is 0 whenever output valid is low.
- R9: While lock is low, stable, resolution valid and producing read 0, and synchronisation is lost. Counts keep their values. Output resumes only at a frame boundary after re-synchronisation, with go still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lock_in | input | 1 | External lock indication |
| vid_act | input | 1 | Sample is active video |
| vid_eol | input | 1 | Last sample of a line |
| vid_field | input | 1 | Field identity of the sample |
| vid_data | input | DW | Sample payload |
| bus_addr | input | AW | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DW | Gated sample payload |

## Verification
A wrong line-length history shows in the stable bit in the cycle after the end-of-line sample that caused it. It then spreads to resolution valid at the next field end. A bad field-open or synchronisation state shows as count words that change after a partial field, or as output that starts in the middle of a field. A bad producing state shows as out_valid on the very first active sample of the wrong field. Each of these is visible within one line or one field of the stimulus that caused it.

// File: rtl/vid_res_detect.sv
module vid_res_detect #(
  parameter int DW = 20,
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_in,
  input  logic          vid_act,
  input  logic          vid_eol,
  input  logic          vid_field,
  input  logic [DW-1:0] vid_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_SAMP = AW'(1);
  localparam logic [AW-1:0] A_F0   = AW'(2);
  localparam logic [AW-1:0] A_F1   = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);

  logic [CW-1:0] pix_cnt, len_h1, len_h2, line_cnt, samp_q, f0_q, f1_q;
  logic [1:0]    hist_n;
  logic sync_q, in_fld, fld_id, prev_fld, have_prev;
  logic stable_q, valid_q, intl_q, go_q, prod_q;

  wire [CW-1:0] line_len = pix_cnt + CW'(vid_act);
  wire act_line  = lock_in && vid_eol && (line_len != '0);
  wire blank_eol = lock_in && vid_eol && (line_len == '0);
  wire fld_end   = blank_eol && in_fld;
  wire frm_start = lock_in && sync_q && !in_fld && vid_act && (pix_cnt == '0) && !vid_field;
  wire stab_now  = (hist_n >= 2'd2) &&
                   (line_len == len_h1 || line_len == len_h2 || len_h1 == len_h2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt <= '0; len_h1 <= '0; len_h2 <= '0; line_cnt <= '0;
      samp_q <= '0; f0_q <= '0; f1_q <= '0; hist_n <= '0;
      sync_q <= 1'b0; in_fld <= 1'b0; fld_id <= 1'b0; prev_fld <= 1'b0;
      have_prev <= 1'b0; stable_q <= 1'b0; valid_q <= 1'b0; intl_q <= 1'b0;
      prod_q <= 1'b0;
    end else if (!lock_in) begin
      pix_cnt <= '0; hist_n <= '0; sync_q <= 1'b0; in_fld <= 1'b0;
      have_prev <= 1'b0; stable_q <= 1'b0; valid_q <= 1'b0; prod_q <= 1'b0;
    end else begin
      pix_cnt <= vid_eol ? '0 : line_len;
      if (frm_start) prod_q <= go_q;
      if (act_line) begin
        len_h1   <= line_len;
        len_h2   <= len_h1;
        if (hist_n != 2'd3) hist_n <= hist_n + 2'd1;
        stable_q <= stab_now;
        valid_q  <= valid_q && stab_now;
        if (sync_q) begin
          line_cnt <= in_fld ? line_cnt + CW'(1) : CW'(1);
          in_fld   <= 1'b1;
          if (!in_fld) fld_id <= vid_field;
        end
      end
      if (blank_eol) begin
        sync_q <= 1'b1;
        in_fld <= 1'b0;
      end
      if (fld_end) begin
        samp_q    <= len_h1;
        if (fld_id) f1_q <= line_cnt;
        else        f0_q <= line_cnt;
        valid_q   <= stable_q;
        have_prev <= 1'b1;
        prev_fld  <= fld_id;
        if (have_prev) intl_q <= (fld_id != prev_fld);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else if (bus_wr && bus_addr == A_CTRL) go_q <= bus_wdata[0];
  end

  assign out_valid = vid_act && lock_in && (frm_start ? go_q : prod_q);
  assign out_data  = out_valid ? vid_data : '0;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {20'd0, lock_in, valid_q, 1'b0, stable_q, intl_q, 6'd0, prod_q};
      A_SAMP:  bus_rdata = 32'(samp_q);
      A_F0:    bus_rdata = 32'(f0_q);
      A_F1:    bus_rdata = 32'(f1_q);
      default: bus_rdata = 32'd0;
    endcase
  end

  p_valid_needs_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> stable_q);
  p_lock_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> !prod_q && !stable_q && !valid_q);
  p_counts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_end |=> $stable(f0_q) && $stable(f1_q) && $stable(samp_q));
  p_out_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vid_act && lock_in);
  p_prod_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prod_q) |-> $past(go_q));
endmodule

// File: tb/test_vid_res_detect.sv
module test_vid_res_detect;
  localparam int DW = 20;
  logic clk = 1'b0, rst_n = 1'b0, lock_in = 1'b0;
  logic vid_act = 1'b0, vid_eol = 1'b0, vid_field = 1'b0;
  logic [DW-1:0] vid_data = '0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic out_valid;
  logic [DW-1:0] out_data;
  int total = 0, bad = 0, ov_cnt = 0, data_err = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  vid_res_detect #(.DW(DW)) i_vid_res_detect (
    .clk, .rst_n, .lock_in, .vid_act, .vid_eol, .vid_field, .vid_data,
    .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .out_valid, .out_data);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic a, input logic e, input logic f);
    @(negedge clk);
    vid_act = a; vid_eol = e; vid_field = f; vid_data = vid_data + 1'b1;
    #1;
    if (out_valid) begin
      ov_cnt++;
      if (out_data != vid_data) data_err++;
    end else if (out_data != '0) data_err++;
  endtask

  task automatic line(input int n, input logic f);
    for (int i = 0; i < n; i++) smp(1'b1, 1'b0, f);
    smp(1'b0, 1'b0, f);
    smp(1'b0, 1'b1, f);
  endtask

  task automatic field(input int nl, input int w, input logic f);
    ov_cnt = 0; data_err = 0;
    for (int i = 0; i < nl; i++) line(w, f);
    line(0, f);
    line(0, f);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    vid_act = 1'b0; vid_eol = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    vid_act = 1'b0; vid_eol = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    rd(4'd0, rv); chk("R1 status after reset", rv, 0);
    for (int a = 1; a < 8; a++) begin
      rd(4'(a), rv); chk("R2 word reads zero after reset", rv, 0);
    end
    lock_in = 1'b1;
    rd(4'd0, rv); chk("R1 lock bit follows input", rv, 32'h800);
  endtask

  task automatic t_partial;
    for (int i = 0; i < 3; i++) line(6, 1'b0);
    line(0, 1'b0); line(0, 1'b0);
    rd(4'd2, rv); chk("R4 partial field leaves f0", rv, 0);
    rd(4'd1, rv); chk("R4 partial field leaves sample count", rv, 0);
  endtask

  task automatic t_progressive;
    field(4, 8, 1'b0);
    rd(4'd1, rv); chk("R3 sample count", rv, 8);
    rd(4'd2, rv); chk("R4 f0 line count", rv, 4);
    rd(4'd0, rv); chk("R5 R6 status stable and valid", rv, 32'hD00);
    field(4, 8, 1'b0);
    rd(4'd0, rv); chk("R7 progressive not interlaced", rv, 32'hD00);
    wr(4'd1, 32'hFFFF); rd(4'd1, rv); chk("R2 count word read-only", rv, 8);
    rd(4'd4, rv); chk("R2 control reads zero", rv, 0);
  endtask

  task automatic t_interlace;
    field(3, 10, 1'b0);
    field(2, 10, 1'b1);
    rd(4'd2, rv); chk("R4 f0 interlaced", rv, 3);
    rd(4'd3, rv); chk("R4 f1 interlaced", rv, 2);
    rd(4'd0, rv); chk("R7 interlaced set", rv, 32'hD80);
    field(3, 10, 1'b0);
    rd(4'd0, rv); chk("R7 interlaced holds on toggle", rv, 32'hD80);
    field(5, 10, 1'b0);
    rd(4'd0, rv); chk("R7 interlaced clears on repeat", rv, 32'hD00);
    rd(4'd3, rv); chk("R4 f1 kept by field 0", rv, 2);
    rd(4'd2, rv); chk("R4 f0 updated", rv, 5);
  endtask

  task automatic t_stable;
    line(5, 1'b0); line(6, 1'b0); line(7, 1'b0);
    rd(4'd0, rv); chk("R5 R6 three distinct lengths", rv & 32'h500, 0);
    line(5, 1'b0);
    rd(4'd0, rv); chk("R5 still distinct", rv & 32'h500, 0);
    line(7, 1'b0);
    rd(4'd0, rv); chk("R5 R6 two of three equal, valid waits", rv & 32'h500, 32'h100);
    line(0, 1'b0); line(0, 1'b0);
    rd(4'd0, rv); chk("R6 valid at field end", rv & 32'h500, 32'h500);
    rd(4'd1, rv); chk("R3 last line length", rv, 7);
    rd(4'd2, rv); chk("R4 five lines", rv, 5);
  endtask

  task automatic t_go;
    wr(4'd4, 32'd1);
    field(3, 8, 1'b1);
    chk("R8 no output before frame boundary", ov_cnt, 0);
    rd(4'd0, rv); chk("R8 producing still clear", rv & 1, 0);
    field(3, 8, 1'b0);
    chk("R8 output from frame boundary", ov_cnt, 24);
    chk("R8 output data matches", data_err, 0);
    rd(4'd0, rv); chk("R8 producing set", rv & 1, 1);
    wr(4'd4, 32'd0);
    field(2, 8, 1'b1);
    chk("R8 stop waits for boundary", ov_cnt, 16);
    field(2, 8, 1'b0);
    chk("R8 stopped at boundary", ov_cnt, 0);
    chk("R8 data zero when idle", data_err, 0);
    rd(4'd0, rv); chk("R8 producing cleared", rv & 1, 0);
  endtask

  task automatic t_lock;
    wr(4'd4, 32'd1);
    field(2, 8, 1'b0);
    chk("R8 restart", ov_cnt, 16);
    @(negedge clk); lock_in = 1'b0;
    rd(4'd0, rv); chk("R9 lock loss clears flags", rv & 32'hD01, 0);
    lock_in = 1'b1;
    ov_cnt = 0;
    for (int i = 0; i < 4; i++) line(6, 1'b0);
    chk("R9 no output before resync", ov_cnt, 0);
    line(0, 1'b0); line(0, 1'b0);
    rd(4'd2, rv); chk("R9 R4 partial field after lock loss", rv, 2);
    rd(4'd1, rv); chk("R9 R3 sample count kept", rv, 8);
    field(2, 8, 1'b0);
    chk("R9 output after resync boundary", ov_cnt, 16);
    rd(4'd0, rv); chk("R9 producing again", rv & 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_partial();
    t_progressive();
    t_interlace();
    t_stable();
    t_go();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule